// File: doc/BRIEF.md
# Framebuffer Virtual Block Address Translator

This block maps a virtual framebuffer address onto a packed physical buffer. Every virtual line is cut into 16-byte blocks. A per-line table entry holds three things: an enable, an inclusive window of valid blocks, and the physical offset of block 0 of that line. Only blocks inside that window occupy physical storage. A per-buffer register adds a buffer offset and supplies the upper address bits. Any access that falls on a disabled line, outside the window, or past the end of a shortened line does not map to memory. Instead, the block reports a default hit and hands back a programmable default word.

Software loads the table and the configuration through a simple write-only register port. A lookup request carries a buffer index and a virtual address. The answer comes one clock later and holds either a physical address or a default hit. If the offset sum of a mapped access does not fit in the offset field, the block raises a sticky flag for that buffer. Software clears the flag explicitly.

Top module: `fb_vblk_xlate`

## Requirements
- R1: After synchronous reset, all overflow flags are 0 and `rsp_valid` is 0. Every line is disabled and the default word is 0, so any lookup returns a default hit with data 0.
- R2: The virtual address splits into three fields: byte-in-block in bits 3:0, block number in bits 11:4, and line number in the bits from 12 upward. A line table entry has two words. The low word is at byte address 0x2000 + 8*line and holds the enable in bit 0, the first valid block in bits 15:8 and the last valid block in bits 23:16. The high word follows it at +4 and holds the 18-bit line offset in bits 21:4.
- R3: A lookup is mapped only when all of these hold: the line is enabled, first <= block <= last, and the block is legal in the current mode. Any other lookup returns `rsp_default`=1, `rsp_data`=default word and `rsp_paddr`=0. The default word is written at address 0x0004.
- R4: Bit 0 of the mode register at address 0x0000 selects the line length: 0 means 256 blocks per line and 1 means 192 blocks per line. In the 192 mode, a block number of 192 or more is unmapped even when the window covers it.
- R5: A mapped lookup returns `rsp_default`=0 and `rsp_data`=0. Its `rsp_paddr` is {base[8:0], S[22:0]}, where S = bufoff*16 + lineoff*16 + block*16 + byte is computed 24 bits wide.
- R6: A mapped lookup with S[23]=1 sets the sticky flag of its buffer. Unmapped lookups never set a flag.
- R7: Writing address 0x0008 clears flag n where data bit n is 1 and leaves flag n alone where it is 0. A set in the same cycle wins over a clear.
- R8: The response appears exactly one cycle after a request with `req_valid`=1. `rsp_valid` is 0 in every other cycle.
- R9: Buffer n is configured at address 0x0010 + 4*n, with its 19-bit offset in bits 22:4 and its 9-bit base in bits 31:23. Bits 3:0 are ignored. `req_buf` picks which buffer's configuration a lookup uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 14 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request strobe |
| req_buf | input | 2 | Buffer index of the request |
| req_vaddr | input | 22 | Virtual address of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_default | output | 1 | Response hit an unmapped location |
| rsp_paddr | output | 32 | Physical address (0 on a default hit) |
| rsp_data | output | 32 | Default word on a default hit, else 0 |
| ovf_flags | output | 4 | Sticky per-buffer overflow flags |

## Verification
Some rules are checked on every cycle by the assertions. A flag only falls after a clear write to its bit, and only rises after an overflow event. A mapped answer carries the requested buffer's base and the byte offset. The 192-block limit always yields a default hit. A response always trails its request by one cycle. The bench's sweeps cover the rest. They check the full arithmetic of the physical address, the exact window edges at the first and last valid blocks, and disabled lines. They also check which buffer's flag an overflowing sum sets, and the partial-clear behaviour seen at the flag outputs.

// File: rtl/fbx_pkg.sv
// Shared field widths, register offsets and types of the framebuffer
// block translator. Assumes a byte-addressed configuration space.
package fbx_pkg;
    localparam int BYTE_W  = 4;    // byte within a 16-byte block
    localparam int BLK_W   = 8;    // block number within a line
    localparam int BOFF_W  = 19;   // buffer offset field
    localparam int BASE_W  = 9;    // physical base MSB field
    localparam int LOFF_W  = 18;   // line offset field
    localparam int SUM_W   = 24;   // offset sum incl. carry bit
    localparam int BLK192_LIMIT = 192;

    localparam int REG_CTRL = 'h0000;
    localparam int REG_DFLT = 'h0004;
    localparam int REG_CLR  = 'h0008;
    localparam int REG_BUF0 = 'h0010;
    localparam int TBL_BASE = 'h2000;

    typedef enum logic {
        BLK256 = 1'b0,
        BLK192 = 1'b1
    } blk_mode_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [BOFF_W-1:0] off;
    } buf_cfg_t;

    typedef struct packed {
        logic [BLK_W-1:0]  first;
        logic [BLK_W-1:0]  last;
        logic [LOFF_W-1:0] loff;
    } line_ent_t;
endpackage

// File: rtl/fbx_cfg_regs.sv
// Global configuration: line mode, default word, per-buffer offset/base,
// and the sticky per-buffer overflow flags. Assumes word-aligned writes.
module fbx_cfg_regs
    import fbx_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int ADDR_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [NBUF-1:0]       ovf_set,
    output blk_mode_e             mode,
    output logic [31:0]           dflt,
    output buf_cfg_t [NBUF-1:0]   buf_cfg,
    output logic [NBUF-1:0]       ovf_flags
);
    logic [NBUF-1:0] clr_hit;

    // Decode the clear mask of a write to the clear register.
    always_comb begin
        clr_hit = '0;
        if (we && addr == ADDR_W'(REG_CLR)) clr_hit = wdata[NBUF-1:0];
    end

    // Mode and default word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= BLK256;
            dflt <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(REG_CTRL)) mode <= blk_mode_e'(wdata[0]);
            if (addr == ADDR_W'(REG_DFLT)) dflt <= wdata;
        end
    end

    // Per-buffer offset and base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_cfg <= '0;
        end else if (we) begin
            for (int n = 0; n < NBUF; n++) begin
                if (addr == ADDR_W'(REG_BUF0 + 4 * n)) begin
                    buf_cfg[n].base <= wdata[31:23];
                    buf_cfg[n].off  <= wdata[22:4];
                end
            end
        end
    end

    // Sticky overflow flags; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flags <= '0;
        else        ovf_flags <= ovf_set | (ovf_flags & ~clr_hit);
    end

    for (genvar n = 0; n < NBUF; n++) begin : g_flag_chk
        // R7: a flag only drops after a clear write naming it
        a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ovf_flags[n]) |-> $past(we && addr == ADDR_W'(REG_CLR) && wdata[n]));
        // R6: a flag only rises after an overflow event of its buffer
        a_r6_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_flags[n]) |-> $past(ovf_set[n]));
        // R7: set has priority over clear
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(ovf_set[n]) |-> ovf_flags[n]);
    end
endmodule

// File: rtl/fbx_line_table.sv
// Per-line table: enable bit (reset to 0), valid block window and line
// offset. Write decode of the table region; registered read, one cycle.
// Assumes LINES is a power of two and no write/read to the same line in
// one cycle (the read then returns the old contents).
module fbx_line_table
    import fbx_pkg::*;
#(
    parameter int LINES  = 1024,
    parameter int ADDR_W = 14,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_line_en,
    output line_ent_t         rd_ent
);
    localparam int TBL_SPAN = 8 * LINES;

    logic [ADDR_W-1:0]       toff;
    logic                    in_tbl;
    logic [IDX_W-1:0]        w_idx;
    logic                    w_hi;
    logic [2*BLK_W-1:0]      win_mem  [LINES];
    logic [LOFF_W-1:0]       loff_mem [LINES];
    logic [LINES-1:0]        en_vec;

    // Locate a write inside the table region.
    always_comb begin
        toff   = addr - ADDR_W'(TBL_BASE);
        in_tbl = (addr >= ADDR_W'(TBL_BASE)) && (int'(toff) < TBL_SPAN);
        w_idx  = toff[IDX_W+2:3];
        w_hi   = toff[2];
    end

    // Window and offset storage, no reset.
    always_ff @(posedge clk) begin
        if (we && in_tbl && !w_hi) win_mem[w_idx]  <= {wdata[15:8], wdata[23:16]};
        if (we && in_tbl &&  w_hi) loff_mem[w_idx] <= wdata[21:4];
    end

    // Line enables, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_vec        <= '0;
        else if (we && in_tbl && !w_hi) en_vec[w_idx] <= wdata[0];
    end

    // Registered read of one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_line_en <= 1'b0;
            rd_ent     <= '0;
        end else if (rd_en) begin
            rd_line_en   <= en_vec[rd_idx];
            rd_ent.first <= win_mem[rd_idx][2*BLK_W-1:BLK_W];
            rd_ent.last  <= win_mem[rd_idx][BLK_W-1:0];
            rd_ent.loff  <= loff_mem[rd_idx];
        end
    end
endmodule

// File: rtl/fbx_xlate_core.sv
// Second lookup stage: holds the request fields, decides mapped versus
// default, forms the physical address and raises overflow events.
// Assumes the table entry arrives registered in step with this stage.
module fbx_xlate_core
    import fbx_pkg::*;
#(
    parameter int NBUF = 4,
    localparam int BUF_W = $clog2(NBUF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [BUF_W-1:0]    req_buf,
    input  logic [BLK_W-1:0]    req_blk,
    input  logic [BYTE_W-1:0]   req_byte,
    input  blk_mode_e           mode,
    input  logic [31:0]         dflt,
    input  buf_cfg_t [NBUF-1:0] buf_cfg,
    input  logic                line_en,
    input  line_ent_t           line_ent,
    output logic                rsp_valid,
    output logic                rsp_default,
    output logic [31:0]         rsp_paddr,
    output logic [31:0]         rsp_data,
    output logic [NBUF-1:0]     ovf_set
);
    logic                valid_q;
    logic [BUF_W-1:0]    buf_q;
    logic [BLK_W-1:0]    blk_q;
    logic [BYTE_W-1:0]   byte_q;
    logic                in_win;
    logic                blk_legal;
    logic                mapped;
    logic [SUM_W-1:0]    sum;
    buf_cfg_t            cur_buf;

    // Hold the request fields for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            buf_q   <= '0;
            blk_q   <= '0;
            byte_q  <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                buf_q  <= req_buf;
                blk_q  <= req_blk;
                byte_q <= req_byte;
            end
        end
    end

    // Mapping decision and offset sum.
    always_comb begin
        cur_buf   = buf_cfg[buf_q];
        in_win    = (blk_q >= line_ent.first) && (blk_q <= line_ent.last);
        blk_legal = (mode == BLK256) || (int'(blk_q) < BLK192_LIMIT);
        mapped    = line_en && in_win && blk_legal;
        sum       = SUM_W'({cur_buf.off, 4'h0})
                  + SUM_W'({line_ent.loff, 4'h0})
                  + SUM_W'({blk_q, byte_q});
    end

    // Response outputs and overflow events.
    always_comb begin
        rsp_valid   = valid_q;
        rsp_default = valid_q && !mapped;
        rsp_paddr   = (valid_q && mapped) ? {cur_buf.base, sum[SUM_W-2:0]} : 32'h0;
        rsp_data    = (valid_q && !mapped) ? dflt : 32'h0;
        ovf_set     = '0;
        if (valid_q && mapped && sum[SUM_W-1]) ovf_set[buf_q] = 1'b1;
    end

    // R4: in 192-block mode, high blocks always give a default hit
    a_r4_mode192_default: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && mode == BLK192 && int'(blk_q) >= BLK192_LIMIT |-> rsp_default);
    // R5: a mapped answer carries the selected base and the byte offset
    a_r5_base_and_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_default |->
            rsp_paddr[31:23] == buf_cfg[buf_q].base && rsp_paddr[3:0] == byte_q);
    // R6: a default hit never raises an overflow event
    a_r6_no_ovf_on_default: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_default |-> ovf_set == '0);
endmodule

// File: rtl/fb_vblk_xlate.sv
// Top of the framebuffer block translator: configuration registers, line
// table with registered read, and the response stage. A lookup answers
// one cycle after its request. Assumes NBUF >= 2, LINES a power of two.
module fb_vblk_xlate
    import fbx_pkg::*;
#(
    parameter int LINES  = 1024,
    parameter int NBUF   = 4,
    parameter int ADDR_W = 14,
    localparam int IDX_W = $clog2(LINES),
    localparam int VA_W  = BYTE_W + BLK_W + IDX_W,
    localparam int BUF_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [BUF_W-1:0]  req_buf,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_default,
    output logic [31:0]       rsp_paddr,
    output logic [31:0]       rsp_data,
    output logic [NBUF-1:0]   ovf_flags
);
    blk_mode_e           mode;
    logic [31:0]         dflt;
    buf_cfg_t [NBUF-1:0] buf_cfg;
    logic [NBUF-1:0]     ovf_set;
    logic                line_en;
    line_ent_t           line_ent;

    fbx_cfg_regs #(.NBUF(NBUF), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ovf_set   (ovf_set),
        .mode      (mode),
        .dflt      (dflt),
        .buf_cfg   (buf_cfg),
        .ovf_flags (ovf_flags)
    );

    fbx_line_table #(.LINES(LINES), .ADDR_W(ADDR_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rd_en      (req_valid),
        .rd_idx     (req_vaddr[VA_W-1:BYTE_W+BLK_W]),
        .rd_line_en (line_en),
        .rd_ent     (line_ent)
    );

    fbx_xlate_core #(.NBUF(NBUF)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_buf     (req_buf),
        .req_blk     (req_vaddr[BYTE_W+BLK_W-1:BYTE_W]),
        .req_byte    (req_vaddr[BYTE_W-1:0]),
        .mode        (mode),
        .dflt        (dflt),
        .buf_cfg     (buf_cfg),
        .line_en     (line_en),
        .line_ent    (line_ent),
        .rsp_valid   (rsp_valid),
        .rsp_default (rsp_default),
        .rsp_paddr   (rsp_paddr),
        .rsp_data    (rsp_data),
        .ovf_set     (ovf_set)
    );

    // R8: every response trails its request by exactly one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid));
endmodule

// File: tb/test_fb_vblk_xlate.sv
`timescale 1ns/1ps
module test_fb_vblk_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_buf = '0;
    logic [21:0] req_vaddr = '0;
    logic        rsp_valid, rsp_default;
    logic [31:0] rsp_paddr, rsp_data;
    logic [3:0]  ovf_flags;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench-side model of the programmed state
    bit        m_en   [1024];
    int        m_fvb  [1024];
    int        m_lvb  [1024];
    int        m_lo   [1024];
    int        m_boff [4];
    int        m_base [4];
    bit        m_mode = 1'b0;
    bit [31:0] m_dflt = '0;
    bit [3:0]  m_flags = '0;

    always #2.5 clk = ~clk;

    fb_vblk_xlate i_fb_vblk_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_buf(req_buf),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_default(rsp_default),
        .rsp_paddr(rsp_paddr), .rsp_data(rsp_data), .ovf_flags(ovf_flags)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 14'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_line(int ln, bit en, int f, int l, int lo);
        wr('h2000 + 8 * ln, {8'h0, 8'(l), 8'(f), 7'h0, en});
        wr('h2004 + 8 * ln, {10'h0, 18'(lo), 4'h0});
        m_en[ln] = en; m_fvb[ln] = f; m_lvb[ln] = l; m_lo[ln] = lo;
    endtask

    task automatic set_buf(int b, int off, int base);
        wr('h10 + 4 * b, {9'(base), 19'(off), 4'hF});   // R9: bits 3:0 ignored
        m_boff[b] = off; m_base[b] = base;
    endtask

    // one lookup: response checked one cycle later, flags the cycle after
    task automatic lookup(int b, int ln, int blk, int by);
        bit        mapped;
        bit [23:0] s;
        bit [31:0] ep, ed;
        string     tag;
        @(negedge clk);
        req_valid = 1'b1; req_buf = 2'(b);
        req_vaddr = {10'(ln), 8'(blk), 4'(by)};
        @(negedge clk);
        req_valid = 1'b0;
        mapped = m_en[ln] && blk >= m_fvb[ln] && blk <= m_lvb[ln] && (!m_mode || blk < 192);
        s = 24'({19'(m_boff[b]), 4'h0}) + 24'({18'(m_lo[ln]), 4'h0}) + 24'({8'(blk), 4'(by)});
        ep = mapped ? {9'(m_base[b]), s[22:0]} : 32'h0;
        ed = mapped ? 32'h0 : m_dflt;
        if (!mapped && m_mode && blk >= 192 && m_en[ln] && blk >= m_fvb[ln] && blk <= m_lvb[ln])
            tag = "R4 mode192 limit";
        else if (!mapped) tag = "R3 default hit";
        else              tag = "R5 mapped address";
        check(tag, {rsp_valid, rsp_default, rsp_paddr, rsp_data[29:0]},
                   {1'b1, !mapped, ep, ed[29:0]});
        check({tag, " data"}, 64'(rsp_data), 64'(ed));
        if (mapped && s[23]) m_flags[b] = 1'b1;
        @(negedge clk);
        check("R8 idle rsp_valid", 64'(rsp_valid), 64'h0);
        check("R6 overflow flags", 64'(ovf_flags), 64'(m_flags));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            m_en[i] = 0; m_fvb[i] = 0; m_lvb[i] = 0; m_lo[i] = 0;
        end
        for (int i = 0; i < 4; i++) begin m_boff[i] = 0; m_base[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        check("R1 flags after reset", 64'(ovf_flags), 64'h0);
        lookup(0, 0, 0, 0);
        lookup(3, 7, 100, 5);

        // program configuration (R2, R9)
        wr('h0004, 32'hC0FFEE01); m_dflt = 32'hC0FFEE01;
        set_buf(0, 'h00100, 'h0A1);
        set_buf(1, 'h12345, 'h1F0);
        set_buf(2, 'h40000, 'h000);
        set_buf(3, 'h7FF00, 'h1FF);
        set_line(0, 1, 0, 255, 'h00010);
        set_line(1, 1, 10, 20, 'h3FFFF);
        set_line(2, 0, 0, 255, 'h01000);   // disabled line
        set_line(3, 1, 190, 250, 'h00200);
        set_line(1023, 1, 5, 5, 'h00ABC);

        // sweeps in both modes over all blocks of four lines (R2..R6, R8, R9)
        for (int md = 0; md < 2; md++) begin
            wr('h0000, 32'(md)); m_mode = md[0];
            for (int ln = 0; ln < 4; ln++)
                for (int blk = 0; blk < 256; blk++)
                    lookup(blk % 4, ln, blk, (blk + ln) % 16);
        end
        // last table line: single-block window edges (R2, R3)
        for (int blk = 4; blk < 7; blk++) lookup(1, 1023, blk, 9);

        // R7: clearing
        check("R7 some flags set before clear", 64'(ovf_flags != 0), 64'h1);
        wr('h0008, 32'h0);
        @(negedge clk);
        check("R7 clear with zero mask", 64'(ovf_flags), 64'(m_flags));
        wr('h0008, 32'h5); m_flags = m_flags & ~4'h5;
        @(negedge clk);
        check("R7 partial clear", 64'(ovf_flags), 64'(m_flags));
        wr('h0008, 32'hF); m_flags = '0;
        @(negedge clk);
        check("R7 full clear", 64'(ovf_flags), 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule